// File: doc/BRIEF.md
# FM Synthesizer Timer and Status Front End

This block is the part of an FM sound generator that a host processor talks to. The host sees two byte addresses. A write to the even address selects a register index. A write to the odd address stores a byte into the register that index selects. Only three indices do anything here: two reload registers for a pair of programmable interval timers and one timer control register. Any other index is latched, and data written to it is dropped.

Each timer counts base-tick pulses through its own prescaler. The second timer's unit is four times as long as the first timer's. When a timer expires it sets its own flag in the status byte and starts its next period at once. A combined interrupt flag summarises the flags that are not masked. The host reads that flag from the status byte and also receives it as an interrupt pin. A mode pin picks the basic two-operator variant or the extended four-operator variant. The mode sets the width of the register index and some fixed bits in the values read back.

Top module: `fmt_timer_host`

## Requirements
- R1: An even-address write (addr[0]=0) latches the index: in basic mode it is wdata with bit 8 forced to 0; in extended mode addr[1] supplies bit 8. An odd-address write goes to the last latched index. Only indices 0x002, 0x003 and 0x004 have any effect; data written to any other index (for example 0x005 or 0x104) changes nothing.
- R2: A data write to index 0x002 sets timer 1's reload count to 256 minus the byte. Once started, timer 1 expires every reload×T1_DIV base ticks.
- R3: A data write to index 0x003 sets timer 2's reload count the same way. Timer 2 expires every reload×T1_DIV×4 base ticks.
- R4: A control write (index 0x004) with bit 7 clear stores the byte. Bit 6 set hides timer 1's flag (status bit 6) and bit 5 set hides timer 2's flag (status bit 5) in reads.
- R5: A control write with bit 7 set clears both timer flags and recomputes status bit 7. The stored control byte, with its mask and run bits, is left unchanged.
- R6: A timer starts from its full reload count only when its run bit (bit 0 for timer 1, bit 1 for timer 2) changes from 0 to 1. It stops when that bit changes from 1 to 0. Writing the same run value again leaves it counting in its current phase.
- R7: On expiry a timer's flag is set whatever its mask bit says, and the timer reloads and keeps running.
- R8: Status bit 7 is recomputed only when a flag is set or cleared: it becomes 1 if any flag is set and not masked, and 0 otherwise. A mask change alone does not recompute it.
- R9: An even-address read returns {bit7, flag1 & ~mask1, flag2 & ~mask2, 5'b0}. In basic mode bits 2 and 1 also read as 1.
- R10: An odd-address read returns 0xFF in basic mode and 0x00 in extended mode.
- R11: The irq output equals status bit 7 delayed by one clock.
- R12: After reset both timers are stopped, the flags, status bit 7 and irq are 0, and the control byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| addr | input | 2 | Bit 0 selects index (0) or data (1); bit 1 is index bit 8 in extended mode |
| wdata | input | 8 | Write byte |
| ext_mode | input | 1 | 1 selects the extended four-operator variant |
| tick | input | 1 | Single-cycle base tick enable |
| rdata | output | 8 | Read byte for the current addr, combinational |
| irq | output | 1 | Registered combined interrupt flag |

## Verification
On every cycle, the assertions check several things. The irq pin trails status bit 7 by one clock. An expiry always sets its flag, and a stopped timer never expires. A flag-reset write keeps the control byte and empties the flags. Status bit 7 matches the masked flags after each expiry. The fixed read bits and the odd-address byte are also checked. Other behaviours show only in the bench's scenarios: the exact expiry periods of both timers, phase being kept when a run bit is rewritten with the same value, restarts after stop, the stale bit 7 after a mask-only change, and indices that are ignored in each mode.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int IDX_W = 9;
  localparam logic [IDX_W-1:0] IDX_RELOAD1 = 9'h002;
  localparam logic [IDX_W-1:0] IDX_RELOAD2 = 9'h003;
  localparam logic [IDX_W-1:0] IDX_CTRL    = 9'h004;

  // control byte fields
  localparam int CB_CLR  = 7;
  localparam int CB_MSK1 = 6;
  localparam int CB_MSK2 = 5;
  localparam int CB_RUN2 = 1;
  localparam int CB_RUN1 = 0;

  localparam int NUM_TMR = 2;
  localparam int CNT_W   = 9;

  typedef struct packed {
    logic start;
    logic stop;
  } tmr_cmd_t;

  function automatic int run_bit(input int t);
    return (t == 0) ? CB_RUN1 : CB_RUN2;
  endfunction

  function automatic int mask_bit(input int t);
    return (t == 0) ? CB_MSK1 : CB_MSK2;
  endfunction
endpackage

// File: rtl/fmt_reset_sync.sv
module fmt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/fmt_regbus.sv
module fmt_regbus
  import fmt_pkg::*;
(
  input  logic                        clk,
  input  logic                        srst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  addr,
  input  logic [7:0]                  wdata,
  input  logic                        ext_mode,
  output logic [IDX_W-1:0]            idx_q,
  output logic [7:0]                  ctrl_q,
  output logic [NUM_TMR-1:0][CNT_W-1:0] reload,
  output tmr_cmd_t [NUM_TMR-1:0]      cmd,
  output logic                        flag_clr
);
  logic [IDX_W-1:0] idx_n;
  logic [7:0]       ctrl_n;
  logic [NUM_TMR-1:0][7:0] rbyte_q, rbyte_n;
  logic             data_wr, ctrl_hit, ctrl_wr;

  always_comb begin
    data_wr  = wr_en & addr[0];
    ctrl_hit = data_wr & (idx_q == IDX_CTRL);
    flag_clr = ctrl_hit & wdata[CB_CLR];
    ctrl_wr  = ctrl_hit & ~wdata[CB_CLR];

    idx_n = idx_q;
    if (wr_en && !addr[0]) idx_n = {ext_mode & addr[1], wdata};

    ctrl_n = ctrl_q;
    if (ctrl_wr) ctrl_n = wdata;

    rbyte_n = rbyte_q;
    if (data_wr && idx_q == IDX_RELOAD1) rbyte_n[0] = wdata;
    if (data_wr && idx_q == IDX_RELOAD2) rbyte_n[1] = wdata;

    for (int t = 0; t < NUM_TMR; t++) begin
      reload[t]    = CNT_W'(256) - {1'b0, rbyte_q[t]};
      cmd[t].start = ctrl_wr &  wdata[run_bit(t)] & ~ctrl_q[run_bit(t)];
      cmd[t].stop  = ctrl_wr & ~wdata[run_bit(t)] &  ctrl_q[run_bit(t)];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      idx_q   <= '0;
      ctrl_q  <= '0;
      rbyte_q <= '0;
    end else begin
      idx_q   <= idx_n;
      ctrl_q  <= ctrl_n;
      rbyte_q <= rbyte_n;
    end
  end
endmodule

// File: rtl/fmt_interval_timer.sv
module fmt_interval_timer
  import fmt_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] reload,
  output logic             ovf
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic             run_q, run_n;
  logic [PW-1:0]    pre_q, pre_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             unit_end;

  always_comb begin
    unit_end = run_q & tick & (pre_q == PRE_LAST);
    ovf      = unit_end & (cnt_q == CNT_W'(1)) & ~cmd.stop;
    run_n = run_q;
    pre_n = pre_q;
    cnt_n = cnt_q;
    if (cmd.start) begin
      run_n = 1'b1;
      pre_n = '0;
      cnt_n = reload;
    end else if (cmd.stop) begin
      run_n = 1'b0;
      pre_n = '0;
      cnt_n = '0;
    end else if (run_q && tick) begin
      if (unit_end) begin
        pre_n = '0;
        cnt_n = (cnt_q == CNT_W'(1)) ? reload : cnt_q - CNT_W'(1);
      end else begin
        pre_n = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      pre_q <= pre_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/fmt_status.sv
module fmt_status
  import fmt_pkg::*;
(
  input  logic               clk,
  input  logic               srst_n,
  input  logic [NUM_TMR-1:0] ovf,
  input  logic               flag_clr,
  input  logic [NUM_TMR-1:0] hide,
  output logic [NUM_TMR-1:0] flag_q,
  output logic               master_q,
  output logic               irq_q
);
  logic [NUM_TMR-1:0] flag_n;
  logic               master_n;
  logic               event_any;

  always_comb begin
    flag_n = flag_q;
    if (flag_clr) flag_n = '0;
    flag_n    = flag_n | ovf;
    event_any = flag_clr | (|ovf);
    master_n  = master_q;
    if (event_any) master_n = |(flag_n & ~hide);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flag_q   <= '0;
      master_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      flag_q   <= flag_n;
      master_q <= master_n;
      irq_q    <= master_q;
    end
  end
endmodule

// File: rtl/fmt_timer_host.sv
module fmt_timer_host
  import fmt_pkg::*;
#(
  parameter int T1_DIV   = 2,
  parameter int T2_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       ext_mode,
  input  logic       tick,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int T2_DIV = T1_DIV * T2_RATIO;

  logic                          srst_n;
  logic [IDX_W-1:0]              idx_q;
  logic [7:0]                    ctrl_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] reload;
  tmr_cmd_t [NUM_TMR-1:0]        cmd;
  logic                          flag_clr;
  logic [NUM_TMR-1:0]            ovf;
  logic [NUM_TMR-1:0]            hide;
  logic [NUM_TMR-1:0]            flag_q;
  logic                          master_q;

  fmt_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  fmt_regbus u_bus (
    .clk      (clk),
    .srst_n   (srst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ext_mode (ext_mode),
    .idx_q    (idx_q),
    .ctrl_q   (ctrl_q),
    .reload   (reload),
    .cmd      (cmd),
    .flag_clr (flag_clr)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    fmt_interval_timer #(
      .DIV ((g == 0) ? T1_DIV : T2_DIV)
    ) u_tmr (
      .clk    (clk),
      .srst_n (srst_n),
      .tick   (tick),
      .cmd    (cmd[g]),
      .reload (reload[g]),
      .ovf    (ovf[g])
    );
    assign hide[g] = ctrl_q[mask_bit(g)];
  end

  fmt_status u_stat (
    .clk      (clk),
    .srst_n   (srst_n),
    .ovf      (ovf),
    .flag_clr (flag_clr),
    .hide     (hide),
    .flag_q   (flag_q),
    .master_q (master_q),
    .irq_q    (irq)
  );

  always_comb begin
    if (addr[0]) begin
      rdata = ext_mode ? 8'h00 : 8'hFF;
    end else begin
      rdata = {master_q, flag_q[0] & ~hide[0], flag_q[1] & ~hide[1], 5'b0};
      if (!ext_mode) rdata[2:1] = 2'b11;
    end
  end
endmodule

// File: rtl/fmt_timer_host_chk.sv
module fmt_timer_host_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       ext_mode,
  input logic [7:0] rdata,
  input logic       irq,
  input logic [8:0] idx_q,
  input logic [7:0] ctrl_q,
  input logic [1:0] ovf,
  input logic [1:0] flag_q,
  input logic       master_q
);
  logic clr_wr;
  assign clr_wr = wr_en & addr[0] & (idx_q == 9'h004) & wdata[7];

  p_irq_trails_r11: assert property (@(posedge clk) disable iff (!srst_n)
    irq == $past(master_q));

  p_odd_read_r10: assert property (@(posedge clk) disable iff (!srst_n)
    addr[0] |-> rdata == (ext_mode ? 8'h00 : 8'hFF));

  p_basic_bits_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (!addr[0] && !ext_mode) |-> rdata[2:1] == 2'b11);

  p_clr_keeps_ctrl_r5: assert property (@(posedge clk) disable iff (!srst_n)
    clr_wr |=> $stable(ctrl_q));

  p_clr_empties_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_wr && ovf == 2'b00) |=> flag_q == 2'b00);

  p_flag1_set_r7: assert property (@(posedge clk) disable iff (!srst_n)
    ovf[0] |=> flag_q[0]);

  p_flag2_set_r7: assert property (@(posedge clk) disable iff (!srst_n)
    ovf[1] |=> flag_q[1]);

  p_stop1_quiet_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q[0] |-> !ovf[0]);

  p_stop2_quiet_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q[1] |-> !ovf[1]);

  p_master_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (|ovf) |=> master_q == ((flag_q[0] & ~$past(ctrl_q[6])) |
                            (flag_q[1] & ~$past(ctrl_q[5]))));
endmodule

bind fmt_timer_host fmt_timer_host_chk u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .ext_mode (ext_mode),
  .rdata    (rdata),
  .irq      (irq),
  .idx_q    (idx_q),
  .ctrl_q   (ctrl_q),
  .ovf      (ovf),
  .flag_q   (flag_q),
  .master_q (master_q)
);

// File: tb/tb_fmt_timer_host.sv
`timescale 1ns/1ps
module tb_fmt_timer_host;
  localparam int D1 = 2;
  localparam int D2 = D1 * 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic       ext_mode = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fmt_timer_host #(.T1_DIV(D1), .T2_RATIO(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ext_mode(ext_mode), .tick(tick), .rdata(rdata), .irq(irq)
  );

  // behavioural reference
  int m_rb1, m_rb2, m_ctrl, m_idx;
  bit m_f1, m_f2, m_all, m_irq, m_run1, m_run2;
  int m_left1, m_left2;

  task automatic model_step();
    bit dw, clr, on1, off1, on2, off2, ex1, ex2;
    int rl1, rl2, old_ctrl;
    if (!rst_n) begin
      m_rb1 = 0; m_rb2 = 0; m_ctrl = 0; m_idx = 0;
      m_f1 = 0; m_f2 = 0; m_all = 0; m_irq = 0;
      m_run1 = 0; m_run2 = 0; m_left1 = 0; m_left2 = 0;
      return;
    end
    dw = wr_en && addr[0];
    rl1 = 256 - m_rb1; rl2 = 256 - m_rb2;
    clr = 0; on1 = 0; off1 = 0; on2 = 0; off2 = 0; ex1 = 0; ex2 = 0;
    old_ctrl = m_ctrl;
    if (dw && m_idx == 4) begin
      if (wdata[7]) clr = 1;
      else begin
        on1  = wdata[0] && !old_ctrl[0];
        off1 = !wdata[0] && old_ctrl[0];
        on2  = wdata[1] && !old_ctrl[1];
        off2 = !wdata[1] && old_ctrl[1];
      end
    end
    if (on1) begin m_run1 = 1; m_left1 = rl1 * D1; end
    else if (off1) m_run1 = 0;
    else if (m_run1 && tick) begin
      m_left1--;
      if (m_left1 == 0) begin ex1 = 1; m_left1 = rl1 * D1; end
    end
    if (on2) begin m_run2 = 1; m_left2 = rl2 * D2; end
    else if (off2) m_run2 = 0;
    else if (m_run2 && tick) begin
      m_left2--;
      if (m_left2 == 0) begin ex2 = 1; m_left2 = rl2 * D2; end
    end
    m_irq = m_all;
    if (clr) begin m_f1 = 0; m_f2 = 0; end
    if (ex1) m_f1 = 1;
    if (ex2) m_f2 = 1;
    if (clr || ex1 || ex2)
      m_all = (m_f1 && !old_ctrl[6]) || (m_f2 && !old_ctrl[5]);
    if (dw && m_idx == 4 && !wdata[7]) m_ctrl = wdata;
    if (dw && m_idx == 2) m_rb1 = wdata;
    if (dw && m_idx == 3) m_rb2 = wdata;
    if (wr_en && !addr[0]) m_idx = (ext_mode && addr[1]) ? 256 + wdata : wdata;
  endtask

  function automatic logic [7:0] model_read();
    logic [7:0] v;
    if (addr[0]) return ext_mode ? 8'h00 : 8'hFF;
    v = {m_all, m_f1 && !m_ctrl[6], m_f2 && !m_ctrl[5], 5'b0};
    if (!ext_mode) v = v | 8'h06;
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(addr[0] ? "R10 model" : "R9 model", rdata, model_read());
    check("R11 model irq", {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0; addr = 2'b00;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
    #1;
  endtask

  task automatic ctrl(input logic [7:0] d);
    wr(2'b00, 8'h04);
    wr(2'b01, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000ns;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    model_step();
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();
    // R12 reset state
    check("R12 status after reset", rdata, 8'h06);
    check("R12 irq after reset", {7'b0, irq}, 8'h00);
    addr = 2'b01; #1;
    check("R10 odd read basic", rdata, 8'hFF);
    addr = 2'b00; #1;

    // timer 1, reload 2
    wr(2'b00, 8'h02); wr(2'b01, 8'hFE);
    ctrl(8'h01);
    ticks(3);
    check("R2 not yet expired", rdata, 8'h06);
    ticks(1);
    check("R2 R7 timer1 expired", rdata, 8'hC6);
    cyc();
    check("R11 irq follows", {7'b0, irq}, 8'h01);

    ctrl(8'h41);
    check("R4 R8 mask hides flag, stale bit7", rdata, 8'h86);
    ctrl(8'h80);
    check("R5 flags cleared", rdata, 8'h06);
    ticks(4);
    check("R7 masked flag invisible", rdata, 8'h06);
    ctrl(8'h01);
    check("R8 R7 unmask shows flag, bit7 stale", rdata, 8'h46);

    // same run value keeps phase
    ctrl(8'h81);
    check("R5 clear with run bit in byte", rdata, 8'h06);
    ticks(2);
    ctrl(8'h01);
    ticks(2);
    check("R6 rewrite same run keeps phase", rdata, 8'hC6);
    ctrl(8'h80);
    ticks(2);
    ctrl(8'h00);
    ctrl(8'h01);
    ticks(2);
    check("R6 restart from full reload", rdata, 8'h06);
    ticks(2);
    check("R6 restarted period", rdata, 8'hC6);
    ctrl(8'h80);
    ctrl(8'h00);
    ticks(8);
    check("R6 stopped timer silent", rdata, 8'h06);

    // timer 2, reload 1
    wr(2'b00, 8'h03); wr(2'b01, 8'hFF);
    ctrl(8'h02);
    ticks(7);
    check("R3 timer2 not yet", rdata, 8'h06);
    ticks(1);
    check("R3 timer2 expired", rdata, 8'hA6);
    ctrl(8'h00);

    // extended mode index bit 8
    ext_mode = 1'b1; #1;
    check("R9 extended status no fixed bits", rdata, 8'hA0);
    wr(2'b10, 8'h04); wr(2'b11, 8'h80);
    check("R1 index 0x104 ignored", rdata, 8'hA0);
    addr = 2'b01; #1;
    check("R10 odd read extended", rdata, 8'h00);
    addr = 2'b00; #1;
    wr(2'b00, 8'h04); wr(2'b01, 8'h80);
    check("R5 clear in extended", rdata, 8'h00);
    ext_mode = 1'b0; #1;

    // basic mode ignores addr[1]; other index ignored
    ctrl(8'h02);
    ticks(8);
    check("R3 timer2 second period", rdata, 8'hA6);
    wr(2'b10, 8'h04); wr(2'b11, 8'h80);
    check("R1 basic drops addr1", rdata, 8'h06);
    wr(2'b00, 8'h05); wr(2'b01, 8'hFF);
    ticks(8);
    check("R1 index 0x005 ignored", rdata, 8'hA6);
    ctrl(8'h22);
    check("R4 mask timer2, stale bit7", rdata, 8'h86);
    for (int i = 0; i < 4; i++) cyc();
    finish_run();
  end
endmodule